// File: doc/BRIEF.md
# Address-Latched Multicart Bank Controller

This block is the cartridge-side bank controller of an 8-bit console multicart. Any CPU write into the upper 32K window loads a control register, and the value stored is taken from the CPU address bus; the data byte is ignored. The stored fields pick a ROM socket, a 32K bank inside that socket, a 16K or 32K page size with a half select, and the nametable mirroring arrangement.

From the register, the block drives the upper PRG ROM address lines and four active-low socket enables. It also drives a shared output enable that is active only for CPU reads of the ROM window, and the nametable RAM A10 line, which gives horizontal, vertical or single-screen mirroring. The video side has no pattern ROM. Pattern-table accesses below 0x2000 go straight through to an 8K writable RAM, with a write enable, so the loaded games can fill their own graphics.

Top module: `addr_latch_mapper`

## Requirements
- R1: After reset the register holds zero: socket 0 is enabled (`rom_ce_n` = 4'b1110), `prg_addr[19:14]` is 0 for either CPU window, and `ciram_a10` follows `ppu_addr[11]`.
- R2: On a rising clock edge where `romsel_n` is 0 and `cpu_rw` is 0, the register loads from `cpu_addr`. On any other edge it keeps its value, including ROM reads and writes with `romsel_n` high.
- R3: Address bits 15, 14 and 7:5 of a register write have no effect on any output.
- R4: When latched bit 10 is 1 (32K pages), `prg_addr[14]` equals `cpu_addr[14]`.
- R5: When latched bit 10 is 0 (16K pages), `prg_addr[14]` equals latched bit 12 in both the 0x8000 and 0xC000 windows.
- R6: `prg_addr[19:15]` equals latched bits 4:0, and `prg_addr[13:0]` equals `cpu_addr[13:0]`.
- R7: Latched bits 9:8 hold a socket number k, and `rom_ce_n[k]` is the only low socket enable.
- R8: When latched bit 11 is 0, `ciram_a10` equals `ppu_addr[10]` if latched bit 13 is 1 (vertical), and `ppu_addr[11]` if latched bit 13 is 0 (horizontal).
- R9: When latched bit 11 is 1, `ciram_a10` is 0 for every `ppu_addr`.
- R10: `chr_addr` equals `ppu_addr[12:0]`. `chr_ce_n` equals `ppu_addr[13]`. `chr_we_n` is low only when `ppu_we_n` is low and `ppu_addr[13]` is 0.
- R11: `rom_oe_n` is low only when `romsel_n` is 0 and `cpu_rw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock; register writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU direction, 1 = read, 0 = write |
| romsel_n | input | 1 | Active-low select for the 0x8000-0xFFFF window |
| ppu_addr | input | 14 | Video-side address bus |
| ppu_we_n | input | 1 | Video-side active-low write strobe |
| prg_addr | output | 20 (PAGE_W+1+BANK_W) | PRG ROM address lines |
| rom_ce_n | output | 4 (2**CHIP_W) | Active-low ROM socket enables |
| rom_oe_n | output | 1 | Active-low ROM output enable |
| ciram_a10 | output | 1 | Nametable RAM address line 10 |
| chr_addr | output | 13 | Pattern RAM address |
| chr_ce_n | output | 1 | Pattern RAM active-low chip enable |
| chr_we_n | output | 1 | Pattern RAM active-low write enable |

## Verification
A register write becomes visible on the first clock edge that sees the strobe. Every field-dependent output then settles combinationally in the low clock phase that follows. The bench therefore applies a write in one low phase, removes it at the next falling edge, and samples the outputs 2 ns after new read addresses are applied, well before the next rising edge. The CPU address pass-through, the output enable and the pattern RAM signals have no register in their path, so they are checked 2 ns after each input change within a single phase.

// File: rtl/alm_pkg.sv
package alm_pkg;

   localparam int CPU_AW     = 16;
   localparam int PPU_AW     = 14;
   localparam int PAGE_W     = 14;
   localparam int CHR_AW     = 13;
   localparam int CHIP_W_MAX = 2;
   localparam int BANK_W_MAX = 5;

   // Field positions in the latched address; the decode depends on them.
   localparam int POS_MIRV   = 13;
   localparam int POS_HALF   = 12;
   localparam int POS_SINGLE = 11;
   localparam int POS_SIZE   = 10;
   localparam int POS_CHIP   = 8;
   localparam int POS_BANK   = 0;

   typedef struct packed {
      logic                  mirror_v;
      logic                  half_hi;
      logic                  single;
      logic                  size32;
      logic [CHIP_W_MAX-1:0] chip;
      logic [BANK_W_MAX-1:0] bank;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '0;

   function automatic ctrl_t ctrl_from_addr(input logic [CPU_AW-1:0] a);
      ctrl_t c;
      logic  unused_ign;
      unused_ign = ^{a[15], a[14], a[7:5]};
      c.mirror_v = a[POS_MIRV];
      c.half_hi  = a[POS_HALF];
      c.single   = a[POS_SINGLE];
      c.size32   = a[POS_SIZE];
      c.chip     = a[POS_CHIP +: CHIP_W_MAX];
      c.bank     = a[POS_BANK +: BANK_W_MAX];
      return c;
   endfunction

endpackage

// File: rtl/alm_ctrl_reg.sv
module alm_ctrl_reg
   import alm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [CPU_AW-1:0] addr_in,
   output ctrl_t             ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= CTRL_RESET;
      else if (wr_stb)
         ctrl_q <= ctrl_from_addr(addr_in);
   end

   // R2: value held whenever no strobe
   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(ctrl_q));

   // R2: strobe captures address-bus fields
   a_r2_load_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (ctrl_q.bank == $past(addr_in[POS_BANK +: BANK_W_MAX]))
              && (ctrl_q.chip == $past(addr_in[POS_CHIP +: CHIP_W_MAX])));

endmodule

// File: rtl/alm_prg_map.sv
module alm_prg_map
   import alm_pkg::*;
#(
   parameter int BANK_W = 5,
   localparam int PRG_W = PAGE_W + 1 + BANK_W
)(
   input  ctrl_t             ctrl,
   input  logic [PAGE_W:0]   cpu_a,
   output logic [PRG_W-1:0]  prg_addr
);

   logic page_bit;
   logic unused_ctrl;

   assign unused_ctrl = ^ctrl;
   assign page_bit    = ctrl.size32 ? cpu_a[PAGE_W] : ctrl.half_hi;
   assign prg_addr    = {ctrl.bank[BANK_W-1:0], page_bit, cpu_a[PAGE_W-1:0]};

endmodule

// File: rtl/alm_chip_decode.sv
module alm_chip_decode #(
   parameter int CHIP_W = 2,
   localparam int NUM_CHIPS = 1 << CHIP_W
)(
   input  logic [CHIP_W-1:0]    chip,
   output logic [NUM_CHIPS-1:0] ce_n
);

   for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_sock
      assign ce_n[i] = (chip != CHIP_W'(i));
   end

endmodule

// File: rtl/alm_mirror_mux.sv
module alm_mirror_mux #(
   parameter bit SINGLE_EN  = 1'b1,
   parameter bit SINGLE_LVL = 1'b0
)(
   input  logic mirror_v,
   input  logic single,
   input  logic ppu_a10,
   input  logic ppu_a11,
   output logic nt_a10
);

   logic two_screen;
   assign two_screen = mirror_v ? ppu_a10 : ppu_a11;

   if (SINGLE_EN) begin : g_single
      assign nt_a10 = single ? SINGLE_LVL : two_screen;
   end else begin : g_two_only
      logic unused_single;
      assign unused_single = single;
      assign nt_a10        = two_screen;
   end

endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
   import alm_pkg::*;
#(
   parameter int BANK_W     = 5,
   parameter int CHIP_W     = 2,
   parameter bit SINGLE_EN  = 1'b1,
   parameter bit SINGLE_LVL = 1'b0,
   localparam int PRG_W     = PAGE_W + 1 + BANK_W,
   localparam int NUM_CHIPS = 1 << CHIP_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CPU_AW-1:0]    cpu_addr,
   input  logic                 cpu_rw,
   input  logic                 romsel_n,
   input  logic [PPU_AW-1:0]    ppu_addr,
   input  logic                 ppu_we_n,
   output logic [PRG_W-1:0]     prg_addr,
   output logic [NUM_CHIPS-1:0] rom_ce_n,
   output logic                 rom_oe_n,
   output logic                 ciram_a10,
   output logic [CHR_AW-1:0]    chr_addr,
   output logic                 chr_ce_n,
   output logic                 chr_we_n
);

   initial begin
      assert (BANK_W >= 1 && BANK_W <= BANK_W_MAX)
         else $error("BANK_W out of range 1..%0d", BANK_W_MAX);
      assert (CHIP_W >= 1 && CHIP_W <= CHIP_W_MAX)
         else $error("CHIP_W out of range 1..%0d", CHIP_W_MAX);
   end

   logic  wr_stb;
   ctrl_t ctrl_q;

   assign wr_stb   = !romsel_n && !cpu_rw;
   assign rom_oe_n = romsel_n || !cpu_rw;

   alm_ctrl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .addr_in (cpu_addr),
      .ctrl_q  (ctrl_q)
   );

   alm_prg_map #(.BANK_W(BANK_W)) u_prg (
      .ctrl     (ctrl_q),
      .cpu_a    (cpu_addr[PAGE_W:0]),
      .prg_addr (prg_addr)
   );

   alm_chip_decode #(.CHIP_W(CHIP_W)) u_dec (
      .chip (ctrl_q.chip[CHIP_W-1:0]),
      .ce_n (rom_ce_n)
   );

   alm_mirror_mux #(.SINGLE_EN(SINGLE_EN), .SINGLE_LVL(SINGLE_LVL)) u_mir (
      .mirror_v (ctrl_q.mirror_v),
      .single   (ctrl_q.single),
      .ppu_a10  (ppu_addr[10]),
      .ppu_a11  (ppu_addr[11]),
      .nt_a10   (ciram_a10)
   );

   // Pattern RAM: only the lower 8K of video space reaches it.
   assign chr_addr = ppu_addr[CHR_AW-1:0];
   assign chr_ce_n = ppu_addr[CHR_AW];
   assign chr_we_n = ppu_we_n || ppu_addr[CHR_AW];

   // R6: bank lines show the written low address bits one cycle later
   a_r6_bank_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> prg_addr[PRG_W-1:PAGE_W+1] == $past(cpu_addr[BANK_W-1:0]));

   // R4: 32K page mode passes CPU A14
   a_r4_full_page: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && cpu_addr[POS_SIZE] |=> prg_addr[PAGE_W] == cpu_addr[PAGE_W]);

   // R5: 16K page mode uses the written half select
   a_r5_half_page: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !cpu_addr[POS_SIZE] |=> prg_addr[PAGE_W] == $past(cpu_addr[POS_HALF]));

   // R7: exactly one socket enabled at any time
   a_r7_one_socket: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~rom_ce_n) == 1);

   // R7: the enabled socket is the one just written
   a_r7_socket_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !rom_ce_n[$past(cpu_addr[POS_CHIP +: CHIP_W])]);

   // R8: vertical mirroring follows PPU A10
   a_r8_vertical: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !cpu_addr[POS_SINGLE] && cpu_addr[POS_MIRV] |=> ciram_a10 == ppu_addr[10]);

   // R9: single-screen forces the fixed level
   a_r9_single_screen: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && cpu_addr[POS_SINGLE] && SINGLE_EN |=> ciram_a10 == SINGLE_LVL);

   // R11: ROM drives the bus only on reads of its window
   a_r11_read_only_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> !romsel_n && cpu_rw);

endmodule

// File: tb/tb_addr_latch_mapper.sv
module tb_addr_latch_mapper;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rw = 1'b1;
   logic        romsel_n = 1'b1;
   logic [13:0] ppu_addr = 14'h0000;
   logic        ppu_we_n = 1'b1;
   logic [19:0] prg_addr;
   logic [3:0]  rom_ce_n;
   logic        rom_oe_n;
   logic        ciram_a10;
   logic [12:0] chr_addr;
   logic        chr_ce_n;
   logic        chr_we_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   addr_latch_mapper dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .romsel_n(romsel_n), .ppu_addr(ppu_addr), .ppu_we_n(ppu_we_n),
      .prg_addr(prg_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
      .ciram_a10(ciram_a10), .chr_addr(chr_addr), .chr_ce_n(chr_ce_n),
      .chr_we_n(chr_we_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] exp_prg(input logic [15:0] wa, input logic [15:0] ra);
      logic a14;
      a14 = wa[10] ? ra[14] : wa[12];
      return {wa[4:0], a14, ra[13:0]};
   endfunction

   function automatic logic [3:0] exp_ce(input logic [15:0] wa);
      return ~(4'b0001 << wa[9:8]);
   endfunction

   function automatic logic exp_a10(input logic [15:0] wa, input logic [13:0] pa);
      if (wa[11]) return 1'b0;
      return wa[13] ? pa[10] : pa[11];
   endfunction

   task automatic do_write(input logic [15:0] wa);
      @(negedge clk);
      cpu_addr = wa; cpu_rw = 1'b0; romsel_n = 1'b0;
      @(negedge clk);
      cpu_rw = 1'b1; romsel_n = 1'b1;
   endtask

   task automatic read_checks(input logic [15:0] wa, input logic [13:0] off);
      cpu_addr = 16'h8000 | {2'b00, off}; romsel_n = 1'b0; cpu_rw = 1'b1;
      #2;
      chk(wa[10] ? "R4 R6 low window" : "R5 R6 low window", 32'(prg_addr), 32'(exp_prg(wa, cpu_addr)));
      cpu_addr = 16'hC000 | {2'b00, off};
      #2;
      chk(wa[10] ? "R4 R6 high window" : "R5 R6 high window", 32'(prg_addr), 32'(exp_prg(wa, cpu_addr)));
      chk("R7 socket enable", 32'(rom_ce_n), 32'(exp_ce(wa)));
      ppu_addr = 14'h2400;
      #2;
      chk(wa[11] ? "R9 single screen" : "R8 mirroring a", 32'(ciram_a10), 32'(exp_a10(wa, ppu_addr)));
      ppu_addr = 14'h2800;
      #2;
      chk(wa[11] ? "R9 single screen" : "R8 mirroring b", 32'(ciram_a10), 32'(exp_a10(wa, ppu_addr)));
      romsel_n = 1'b1;
   endtask

   initial begin
      logic [15:0] last_wa;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cpu_addr = 16'hC123; romsel_n = 1'b0; cpu_rw = 1'b1; ppu_addr = 14'h2800;
      #2;
      chk("R1 reset prg", 32'(prg_addr), 32'h00123);
      chk("R1 reset sockets", 32'(rom_ce_n), 32'hE);
      chk("R1 reset mirroring", 32'(ciram_a10), 32'h1);
      romsel_n = 1'b1;

      // R2 R3 R4 R5 R6 R7 R8 R9 sweep; ignored bits 14 and 7:5 vary
      last_wa = 16'h8000;
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 32; b++)
            for (int r = 0; r < 2; r++)
               for (int p = 0; p < 2; p++) begin
                  logic [15:0] wa;
                  logic [2:0]  junk;
                  junk = 3'(b) ^ 3'(c);
                  wa = {1'b1, b[3], b[0], p[0], b[1], r[0], c[1:0], junk, b[4:0]};
                  do_write(wa);
                  read_checks(wa, 14'(b * 517 + c * 33 + r * 4099));
                  last_wa = wa;
               end

      // R3: same fields, ignored bits flipped, same outputs
      do_write(16'h8A15);
      read_checks(16'h8A15, 14'h1234);
      do_write(16'hCAF5);
      read_checks(16'h8A15, 14'h1234);
      last_wa = 16'hCAF5;

      // R2: read cycle and a strobe-less write must not load
      @(negedge clk);
      cpu_addr = 16'hFFFF; cpu_rw = 1'b1; romsel_n = 1'b0;
      @(negedge clk);
      cpu_addr = 16'h7F1F; cpu_rw = 1'b0; romsel_n = 1'b1;
      @(negedge clk);
      cpu_rw = 1'b1;
      cpu_addr = 16'hC000; romsel_n = 1'b0;
      #2;
      chk("R2 hold prg", 32'(prg_addr), 32'(exp_prg(last_wa, cpu_addr)));
      chk("R2 hold sockets", 32'(rom_ce_n), 32'(exp_ce(last_wa)));
      romsel_n = 1'b1;

      // R11 output enable over all strobe combinations
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         romsel_n = i[0]; cpu_rw = i[1]; cpu_addr = 16'h9000;
         #2;
         chk("R11 output enable", 32'(rom_oe_n), 32'(!(!i[0] && i[1])));
         romsel_n = 1'b1; cpu_rw = 1'b1;
      end

      // R10 pattern RAM pass-through
      for (int i = 0; i < 64; i++) begin
         ppu_addr = 14'(i * 263);
         ppu_we_n = i[0];
         #2;
         chk("R10 pattern addr", 32'(chr_addr), 32'(ppu_addr[12:0]));
         chk("R10 pattern ce", 32'(chr_ce_n), 32'(ppu_addr[13]));
         chk("R10 pattern we", 32'(chr_we_n), 32'(ppu_we_n | ppu_addr[13]));
      end
      ppu_we_n = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule